// File: doc/BRIEF.md
# Latency-Aligned Cascadable FIFO Stage

This block is a single-clock first-in first-out buffer. Its depth is a free parameter, and a depth that is not a power of two works the same as any other. The full flag rises on the exact write that fills the last slot. Read data comes out of a registered pipeline a fixed number of clocks after the read is accepted. That latency is a parameter of one or two cycles.

The stage is built to be chained. The downstream write strobe is the accepted read delayed by the read latency, so it marks the exact cycle in which the data word is present on the output bus. That strobe can drive the next stage's write enable directly. The almost-full flag compares the occupancy against a threshold taken from an input. When the threshold is the depth minus the read latency and the flag drives the stage's own read enable, reads begin just early enough. The first word then leaves in the cycle the buffer would have filled. After the fill, every stage of a chain moves one word per clock with no bubbles.

Top module: `lat_fifo_stage`

## Requirements
- R1: With DEPTH=10, `full` is 1 exactly when 10 words are held; it rises after the tenth write with no reads in between, never earlier or later.
- R2: After reset `empty`=1, `full`=0, `afull`=0 and `dn_we`=0; `empty` is 1 exactly when no word is held.
- R3: A write request while full with no read in the same cycle is dropped: the occupancy stays at DEPTH and the stored words are unchanged.
- R4: A read request while empty is ignored: no `dn_we` pulse follows and the occupancy stays zero.
- R5: An accepted read produces `dn_we`=1 with the word on `rd_data` exactly LAT cycles later (LAT=2 default, LAT=1 also supported), for exactly one cycle per accepted read.
- R6: `afull` is 1 exactly when the occupancy is greater than or equal to `afull_lvl`.
- R7: Read and write requested together while full are both accepted; the stage stays full and order is kept.
- R8: Read and write requested together while empty: the write is accepted and the read is ignored.
- R9: Words leave in the order they were accepted, and the read and write pointers wrap from DEPTH-1 to 0.
- R10: Three stages (DEPTH=10, LAT=2, `afull_lvl`=8, each stage's `rd_en` tied to its own `afull`, `dn_we`/`rd_data` feeding the next stage) fed one word per clock deliver every word in order, on consecutive clocks once the first word leaves, and no stage ever becomes full.
- R11: A synchronous reset clears the occupancy, the pointers and the read pipeline: in the cycle after reset `empty`=1 and `dn_we`=0, even with reads in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| afull_lvl | input | CW | Almost-full threshold in words |
| wr_en | input | 1 | Write request |
| wr_data | input | W | Write data |
| rd_en | input | 1 | Read request |
| rd_data | output | W | Read data, valid when `dn_we` is 1 |
| dn_we | output | 1 | Accepted read delayed by LAT; data-valid and downstream write enable |
| full | output | 1 | Occupancy equals DEPTH |
| afull | output | 1 | Occupancy at or above `afull_lvl` |
| empty | output | 1 | Occupancy is zero |

## Verification
A wrong occupancy count shows on the flags in the very next cycle: `full` at the wrong write count, `empty` failing to clear, or `afull` off by one. A wrong pointer stays hidden until the affected word reaches the read pipeline, and then appears LAT cycles later as a word out of order or repeated. A latency pipeline that is too short or too long moves `dn_we` away from the data. In the chain this opens a gap at the first stage boundary, within a few cycles of the first word leaving the last stage.

// File: rtl/lfs_pkg.sv
package lfs_pkg;

    // Occupancy operation decoded from {write accepted, read accepted}
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_POP  = 2'b01,
        OP_PUSH = 2'b10,
        OP_BOTH = 2'b11
    } lfs_op_e;

endpackage

// File: rtl/lfs_wrap_ptr.sv
module lfs_wrap_ptr #(
    parameter int DEPTH = 10,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [PW-1:0] ptr
);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    typedef struct packed {
        logic [PW-1:0] ptr;
    } ptr_st_t;

    ptr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            st_d.ptr = (st_q.ptr == LAST) ? '0 : st_q.ptr + PW'(1);
        end
        if (rst) begin
            st_d.ptr = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ptr = st_q.ptr;

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
        (adv && st_q.ptr == LAST) |=> (st_q.ptr == '0)) else $error("pointer did not wrap"); // R9

endmodule

// File: rtl/lfs_occ.sv
module lfs_occ
    import lfs_pkg::*;
#(
    parameter int DEPTH = 10,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] lvl,
    input  logic          wr_req,
    input  logic          rd_req,
    output logic          wr_ok,
    output logic          rd_ok,
    output logic          full,
    output logic          afull,
    output logic          empty
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } occ_st_t;

    occ_st_t st_d, st_q;
    lfs_op_e op;

    always_comb begin
        rd_ok = rd_req && (st_q.cnt != '0);
        wr_ok = wr_req && ((st_q.cnt != FULL_CNT) || rd_ok);
        op    = lfs_op_e'({wr_ok, rd_ok});
        st_d  = st_q;
        unique case (op)
            OP_PUSH: st_d.cnt = st_q.cnt + CW'(1);
            OP_POP:  st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
        if (rst) begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign full  = (st_q.cnt == FULL_CNT);
    assign empty = (st_q.cnt == '0);
    assign afull = (st_q.cnt >= lvl);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= FULL_CNT) else $error("occupancy beyond depth"); // R1
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (full && wr_req && !rd_req) |=> (full && $stable(st_q.cnt))) else $error("write while full changed count"); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_req && !wr_req) |=> empty) else $error("read while empty changed count"); // R4
    AST_FULL_BOTH: assert property (@(posedge clk) disable iff (rst)
        (full && wr_req && rd_req) |=> full) else $error("full with read and write lost a slot"); // R7
    AST_EMPTY_BOTH: assert property (@(posedge clk) disable iff (rst)
        (empty && wr_req && rd_req) |=> (st_q.cnt == CW'(1))) else $error("empty with read and write miscounted"); // R8

endmodule

// File: rtl/lfs_rdpipe.sv
module lfs_rdpipe #(
    parameter int W   = 8,
    parameter int LAT = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rd_ok,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         vld
);
    typedef struct packed {
        logic         vld;
        logic [W-1:0] data;
    } slot_t;

    slot_t [LAT-1:0] st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d[0].vld = rd_ok;
        if (rd_ok) begin
            st_d[0].data = din;
        end
        for (int i = 1; i < LAT; i++) begin
            st_d[i] = st_q[i-1];
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout = st_q[LAT-1].data;
    assign vld  = st_q[LAT-1].vld;

    // cycles since reset, saturating, so $past never reaches before reset
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst)                age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    AST_LAT_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd3) |-> (vld == $past(rd_ok, LAT))) else $error("strobe not aligned to read latency"); // R5

endmodule

// File: rtl/lat_fifo_stage.sv
module lat_fifo_stage #(
    parameter int W     = 8,
    parameter int DEPTH = 10,
    parameter int LAT   = 2,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] afull_lvl,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    output logic [W-1:0]  rd_data,
    output logic          dn_we,
    output logic          full,
    output logic          afull,
    output logic          empty
);
    logic          wr_ok, rd_ok;
    logic [PW-1:0] wptr, rptr;
    logic [W-1:0]  mem [DEPTH];

    lfs_occ #(.DEPTH(DEPTH)) u_occ (
        .clk(clk), .rst(rst), .lvl(afull_lvl),
        .wr_req(wr_en), .rd_req(rd_en),
        .wr_ok(wr_ok), .rd_ok(rd_ok),
        .full(full), .afull(afull), .empty(empty)
    );

    lfs_wrap_ptr #(.DEPTH(DEPTH)) u_wptr (
        .clk(clk), .rst(rst), .adv(wr_ok), .ptr(wptr)
    );

    lfs_wrap_ptr #(.DEPTH(DEPTH)) u_rptr (
        .clk(clk), .rst(rst), .adv(rd_ok), .ptr(rptr)
    );

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wptr] <= wr_data;
        end
    end

    lfs_rdpipe #(.W(W), .LAT(LAT)) u_pipe (
        .clk(clk), .rst(rst), .rd_ok(rd_ok),
        .din(mem[rptr]), .dout(rd_data), .vld(dn_we)
    );

    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
        (wptr < PW'(DEPTH)) && (rptr < PW'(DEPTH))) else $error("pointer out of range"); // R9
    AST_RST_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (empty && !dn_we)) else $error("reset left state behind"); // R11
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(full && empty)) else $error("full and empty together"); // R2

endmodule

// File: tb/sim_lat_fifo_stage.sv
module sim_lat_fifo_stage;
    localparam int DEPTH = 10;
    localparam int LVL   = 8;
    localparam int NV    = 52;

    // {write request, read request} per cycle
    localparam logic [1:0] VEC [NV] = '{
        2'b10, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10, // 0-10 fill, R1, R3
        2'b00,                                                                         // 11
        2'b11, 2'b11, 2'b11,                                                           // 12-14 R7
        2'b00,                                                                         // 15
        2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01,          // 16-25 drain
        2'b01, 2'b01, 2'b01,                                                           // 26-28 R4
        2'b00, 2'b00,                                                                  // 29-30
        2'b11, 2'b11,                                                                  // 31-32 R8
        2'b01, 2'b01, 2'b01,                                                           // 33-35
        2'b00, 2'b00,                                                                  // 36-37
        2'b10, 2'b10, 2'b10, 2'b10, 2'b10,                                             // 38-42
        2'b11, 2'b11,                                                                  // 43-44
        2'b01, 2'b01, 2'b01, 2'b01,                                                    // 45-48
        2'b00, 2'b00, 2'b00                                                            // 49-51
    };

    logic clk = 1'b0;
    always #4 clk = ~clk; // 125 MHz

    logic       rst = 1'b1;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] wdat = '0;
    logic [7:0] dout;
    logic       dn_we, full, afull, empty;

    int checks = 0;
    int fails  = 0;

    lat_fifo_stage #(.W(8), .DEPTH(DEPTH), .LAT(2)) u0 (
        .clk(clk), .rst(rst), .afull_lvl(4'(LVL)),
        .wr_en(wr), .wr_data(wdat), .rd_en(rd),
        .rd_data(dout), .dn_we(dn_we),
        .full(full), .afull(afull), .empty(empty)
    );

    // three-stage chain
    logic       src_we = 1'b0;
    logic [7:0] src_d = '0;
    logic [7:0] c1_d, c2_d, c3_d;
    logic       c1_we, c2_we, c3_we;
    logic       c1_f, c2_f, c3_f, c1_af, c2_af, c3_af;
    logic       c1_e, c2_e, c3_e;

    lat_fifo_stage #(.W(8), .DEPTH(DEPTH), .LAT(2)) u_c1 (
        .clk(clk), .rst(rst), .afull_lvl(4'(LVL)),
        .wr_en(src_we), .wr_data(src_d), .rd_en(c1_af),
        .rd_data(c1_d), .dn_we(c1_we), .full(c1_f), .afull(c1_af), .empty(c1_e)
    );
    lat_fifo_stage #(.W(8), .DEPTH(DEPTH), .LAT(2)) u_c2 (
        .clk(clk), .rst(rst), .afull_lvl(4'(LVL)),
        .wr_en(c1_we), .wr_data(c1_d), .rd_en(c2_af),
        .rd_data(c2_d), .dn_we(c2_we), .full(c2_f), .afull(c2_af), .empty(c2_e)
    );
    lat_fifo_stage #(.W(8), .DEPTH(DEPTH), .LAT(2)) u_c3 (
        .clk(clk), .rst(rst), .afull_lvl(4'(LVL)),
        .wr_en(c2_we), .wr_data(c2_d), .rd_en(c3_af),
        .rd_data(c3_d), .dn_we(c3_we), .full(c3_f), .afull(c3_af), .empty(c3_e)
    );

    // one-cycle latency variant
    logic       l_wr = 1'b0, l_rd = 1'b0;
    logic [7:0] l_wd = '0, l_dout;
    logic       l_we, l_full, l_afull, l_empty;

    lat_fifo_stage #(.W(8), .DEPTH(5), .LAT(1)) u_l1 (
        .clk(clk), .rst(rst), .afull_lvl(3'd4),
        .wr_en(l_wr), .wr_data(l_wd), .rd_en(l_rd),
        .rd_data(l_dout), .dn_we(l_we),
        .full(l_full), .afull(l_afull), .empty(l_empty)
    );

    // reference model
    logic [7:0] mq[$];
    logic       mp_v [2];
    logic [7:0] mp_d [2];

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic model_clear();
        mq.delete();
        mp_v[0] = 1'b0; mp_v[1] = 1'b0;
        mp_d[0] = '0;   mp_d[1] = '0;
    endtask

    // compare current outputs, drive one cycle, advance the model
    task automatic step(input logic w, input logic r, input logic [7:0] d, input logic rs);
        int  n;
        logic ra, wa;
        n = mq.size();
        chk("R1 full", {7'b0, full}, {7'b0, n == DEPTH});
        chk("R6 afull", {7'b0, afull}, {7'b0, n >= LVL});
        chk("R2 empty", {7'b0, empty}, {7'b0, n == 0});
        chk("R5 dn_we", {7'b0, dn_we}, {7'b0, mp_v[1]});
        if (mp_v[1]) chk("R9 order", dout, mp_d[1]);
        wr = w; rd = r; wdat = d; rst = rs;
        if (rs) begin
            model_clear();
        end else begin
            ra = r && (n != 0);
            wa = w && ((n != DEPTH) || ra);
            mp_v[1] = mp_v[0]; mp_d[1] = mp_d[0];
            mp_v[0] = ra;
            if (ra) mp_d[0] = mq.pop_front();
            if (wa) mq.push_back(d);
        end
        @(negedge clk);
    endtask

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog: got %0d cycles expected under 20000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2: reset state
        chk("R2 reset empty", {7'b0, empty}, 8'd1);
        chk("R2 reset full", {7'b0, full}, 8'd0);
        chk("R2 reset afull", {7'b0, afull}, 8'd0);
        chk("R2 reset dn_we", {7'b0, dn_we}, 8'd0);

        // table walk: R1 R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][1], VEC[i][0], 8'(i * 7 + 3), 1'b0);
            if (i == 10) chk("R1 full after ten writes", {7'b0, full}, 8'd1);
            if (i == 11) chk("R3 dropped write keeps full", {7'b0, full}, 8'd1);
        end

        // R11: reset with reads in flight
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 8'(8'hC0 + i), 1'b0);
        step(1'b0, 1'b1, 8'h00, 1'b0);
        step(1'b0, 1'b1, 8'h00, 1'b0);
        step(1'b0, 1'b0, 8'h00, 1'b1);
        chk("R11 empty after reset", {7'b0, empty}, 8'd1);
        chk("R11 dn_we after reset", {7'b0, dn_we}, 8'd0);
        step(1'b0, 1'b0, 8'h00, 1'b0);
        chk("R11 no late strobe", {7'b0, dn_we}, 8'd0);

        // R10: three-stage chain, one word per clock
        begin
            int nout = 0;
            int started = 0;
            for (int k = 0; k < 110; k++) begin
                if (c3_we) begin
                    chk("R10 chain order", c3_d, 8'(nout));
                    nout++;
                    started = 1;
                end else if (started != 0 && nout < 40) begin
                    fails++; checks++;
                    $display("FAIL R10 gap: got dn_we 0 expected 1 after %0d words", nout);
                end
                if (c1_f || c2_f || c3_f) begin
                    fails++; checks++;
                    $display("FAIL R10 full: got 1 expected 0 at cycle %0d", k);
                end
                src_we = (k < 80);
                src_d  = 8'(k);
                @(negedge clk);
            end
            src_we = 1'b0;
            chk("R10 delivered count", 8'(nout >= 40), 8'd1);
        end

        // R5: one-cycle latency variant
        chk("R5 lat1 empty", {7'b0, l_empty}, 8'd1);
        l_wr = 1'b1; l_wd = 8'hA5;
        @(negedge clk);
        l_wr = 1'b0; l_rd = 1'b1;
        @(negedge clk);
        l_rd = 1'b0;
        chk("R5 lat1 strobe", {7'b0, l_we}, 8'd1);
        chk("R5 lat1 data", l_dout, 8'hA5);
        @(negedge clk);
        chk("R5 lat1 single pulse", {7'b0, l_we}, 8'd0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule